// File: doc/BRIEF.md
# Stack Pointer With Bounds Check

This block keeps the pointer of a downward-growing system stack of 16-bit words held in on-chip RAM. A push moves the pointer down by one word before the access, and a pop accesses the current word and then moves the pointer up. For each access the block supplies the RAM byte address. The default configuration sets aside a 1024-byte stack region.

Every push is checked against a programmable low limit, and every pop against a programmable high limit. An access that leaves the pointer outside the allowed window still completes. It also raises a sticky trap flag, which stays set until software clears it. Software can load the pointer and both limits through write strobes that share one data bus.

Top module: `stack_guard`

## Requirements
- R1: After reset the pointer is SP_RST, the low limit is OVL_RST, the high limit is UNL_RST, and both trap outputs are 0.
- R2: A push (push=1, pop=0, wr_sp=0) drives ram_addr to sp-2 in the same cycle, and sp equals sp-2 (modulo 2^ADDR_W) after the next clock edge.
- R3: A pop (pop=1, push=0, wr_sp=0) drives ram_addr to sp in the same cycle, and sp equals sp+2 (modulo 2^ADDR_W) after the next clock edge.
- R4: A push with sp < low_limit+2 sets ovf_trap at the next edge. The comparison uses unsigned values one bit wider than ADDR_W, so pushing from sp=0 always traps.
- R5: A pop with sp+2 > high_limit sets unf_trap at the next edge. The comparison uses unsigned values one bit wider than ADDR_W, so popping from the top word always traps.
- R6: Each trap flag stays set until its clear input is pulsed. When a new trap event and the clear input arrive in the same cycle, the flag stays set.
- R7: Bit 0 of wr_data is stored as 0 in the pointer and in both limits, so sp is always even.
- R8: When push and pop are both 1, neither is performed: sp is unchanged, no trap is set, and ram_addr equals sp.
- R9: wr_sp=1 loads the pointer and cancels any push or pop in the same cycle, including its trap check. A limit written in the same cycle as an access is used from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| wr_sp | input | 1 | Load pointer from wr_data |
| wr_ovl | input | 1 | Load low (overflow) limit from wr_data |
| wr_unl | input | 1 | Load high (underflow) limit from wr_data |
| wr_data | input | ADDR_W | Register write data, bit 0 ignored |
| clr_ovf | input | 1 | Clear overflow trap |
| clr_unf | input | 1 | Clear underflow trap |
| ram_addr | output | ADDR_W | RAM byte address of the current access |
| sp | output | ADDR_W | Current stack pointer |
| ovf_trap | output | 1 | Sticky stack-overflow trap |
| unf_trap | output | 1 | Sticky stack-underflow trap |

## Verification
On every cycle the assertions check the following:
- the pointer stays even;
- a push or pop moves the pointer by one word and presents the right address;
- the limit comparisons set the right trap flag;
- the flags stay sticky, and a flag only rises after an access;
- a collided push and pop leaves the pointer unchanged.

The bench's sweeps show what the assertions cannot:
- the exact trap decision across every even pointer value against many limit values, including the wrap cases at zero and at the top of the address space;
- the reset values;
- the alignment of limits that only their effect on later comparisons reveals;
- the ordering of a pointer write against an access, and of a trap set against a clear.

// File: rtl/stack_guard.sv
module stack_guard #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] SP_RST  = 16'hFC00,
  parameter logic [ADDR_W-1:0] OVL_RST = 16'hF800,
  parameter logic [ADDR_W-1:0] UNL_RST = 16'hFC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              wr_sp,
  input  logic              wr_ovl,
  input  logic              wr_unl,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              clr_ovf,
  input  logic              clr_unf,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [ADDR_W-1:0] sp,
  output logic              ovf_trap,
  output logic              unf_trap
);
  localparam int AW1 = ADDR_W + 1;

  logic [ADDR_W-1:0] sp_q, ovl_q, unl_q;
  logic              ovf_q, unf_q;

  wire do_push = push & ~pop & ~wr_sp;
  wire do_pop  = pop & ~push & ~wr_sp;

  wire [ADDR_W-1:0] sp_dec = sp_q - ADDR_W'(2);
  wire [ADDR_W-1:0] sp_inc = sp_q + ADDR_W'(2);
  wire [ADDR_W-1:0] wdata  = {wr_data[ADDR_W-1:1], 1'b0};

  wire ovf_hit = do_push & ({1'b0, sp_q} < ({1'b0, ovl_q} + AW1'(2)));
  wire unf_hit = do_pop  & (({1'b0, sp_q} + AW1'(2)) > {1'b0, unl_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= SP_RST & ~ADDR_W'(1);
      ovl_q <= OVL_RST & ~ADDR_W'(1);
      unl_q <= UNL_RST & ~ADDR_W'(1);
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (wr_sp)        sp_q <= wdata;
      else if (do_push) sp_q <= sp_dec;
      else if (do_pop)  sp_q <= sp_inc;
      if (wr_ovl) ovl_q <= wdata;
      if (wr_unl) unl_q <= wdata;
      ovf_q <= ovf_hit | (ovf_q & ~clr_ovf);
      unf_q <= unf_hit | (unf_q & ~clr_unf);
    end
  end

  assign ram_addr = (push & ~pop) ? sp_dec : sp_q;
  assign sp       = sp_q;
  assign ovf_trap = ovf_q;
  assign unf_trap = unf_q;
endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pop,
  input logic              wr_sp,
  input logic              clr_ovf,
  input logic              clr_unf,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ovf_trap,
  input logic              unf_trap,
  input logic [ADDR_W-1:0] ovl,
  input logic [ADDR_W-1:0] unl
);
  AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rst_n) sp[0] == 1'b0); // R7
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> ram_addr == ADDR_W'(sp - ADDR_W'(2))); // R2
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !wr_sp) |=> sp == ADDR_W'($past(sp) - ADDR_W'(2))); // R2
  AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |-> ram_addr == sp); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !wr_sp) |=> sp == ADDR_W'($past(sp) + ADDR_W'(2))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !wr_sp && ({1'b0, sp} < {1'b0, ovl} + 2)) |=> ovf_trap); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !wr_sp && ({1'b0, sp} + 2 > {1'b0, unl})) |=> unf_trap); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap && !clr_ovf) |=> ovf_trap); // R6
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_trap && !clr_unf) |=> unf_trap); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_trap && !(push && !pop && !wr_sp)) |=> !ovf_trap); // R4
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!unf_trap && !(pop && !push && !wr_sp)) |=> !unf_trap); // R5
  AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !wr_sp) |=> $stable(sp)); // R8
endmodule

bind stack_guard stack_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wr_sp(wr_sp),
  .clr_ovf(clr_ovf), .clr_unf(clr_unf), .sp(sp), .ram_addr(ram_addr),
  .ovf_trap(ovf_trap), .unf_trap(unf_trap), .ovl(ovl_q), .unl(unl_q)
);

// File: tb/stack_guard_bench.sv
`timescale 1ns/100ps
module stack_guard_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 0, pop = 0, wr_sp = 0, wr_ovl = 0, wr_unl = 0, clr_ovf = 0, clr_unf = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] ram_addr, sp;
  logic ovf_trap, unf_trap;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stack_guard #(.ADDR_W(W), .SP_RST(8'hC0), .OVL_RST(8'h80), .UNL_RST(8'hC0)) u_stack_guard (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wr_sp(wr_sp), .wr_ovl(wr_ovl),
    .wr_unl(wr_unl), .wr_data(wr_data), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .ram_addr(ram_addr), .sp(sp), .ovf_trap(ovf_trap), .unf_trap(unf_trap));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask

  task automatic load(input logic [2:0] sel, input int v);
    nxt(); wr_sp = sel[0]; wr_ovl = sel[1]; wr_unl = sel[2]; wr_data = W'(v);
    nxt(); wr_sp = 0; wr_ovl = 0; wr_unl = 0;
  endtask

  task automatic clear_both();
    clr_ovf = 1; clr_unf = 1; nxt(); clr_ovf = 0; clr_unf = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) nxt();
    chk("R1 sp", sp, 'hC0);
    chk("R1 ovf", ovf_trap, 0);
    chk("R1 unf", unf_trap, 0);
    rst_n = 1;
    nxt();
    chk("R1 sp held", sp, 'hC0);
    // R1 reset limits: push from 0x82 no trap, then from 0x80 trap
    load(3'b001, 'h82); push = 1; nxt(); push = 0;
    chk("R1 low limit 0x80 (no trap at 0x80)", ovf_trap, 0);
    push = 1; nxt(); push = 0;
    chk("R1 low limit 0x80 (trap at 0x7E)", ovf_trap, 1);
    clear_both();
    load(3'b001, 'hBE); pop = 1; nxt(); pop = 0;
    chk("R1 high limit 0xC0 (no trap)", unf_trap, 0);
    pop = 1; nxt(); pop = 0;
    chk("R1 high limit 0xC0 (trap)", unf_trap, 1);
    clear_both();
    chk("R6 clear unf", unf_trap, 0);

    // R2/R4 sweep
    for (int o = 0; o < 256; o += 4) begin
      load(3'b010, o);
      for (int s = 0; s < 256; s += 2) begin
        load(3'b001, s);
        push = 1; #1;
        chk("R2 push addr", ram_addr, (s - 2) & 'hFF);
        nxt(); push = 0;
        chk("R2 push sp", sp, (s - 2) & 'hFF);
        chk("R4 overflow", ovf_trap, (s < o + 2) ? 1 : 0);
        clear_both();
      end
    end
    // R3/R5 sweep
    for (int u = 0; u < 256; u += 4) begin
      load(3'b100, u);
      for (int s = 0; s < 256; s += 2) begin
        load(3'b001, s);
        pop = 1; #1;
        chk("R3 pop addr", ram_addr, s);
        nxt(); pop = 0;
        chk("R3 pop sp", sp, (s + 2) & 'hFF);
        chk("R5 underflow", unf_trap, (s + 2 > u) ? 1 : 0);
        clear_both();
      end
    end

    // R6 sticky, set beats clear
    load(3'b010, 'h40); load(3'b001, 'h40);
    push = 1; nxt(); push = 0;
    chk("R6 set", ovf_trap, 1);
    load(3'b001, 'h80); pop = 1; nxt(); pop = 0;
    chk("R6 sticky across pop", ovf_trap, 1);
    load(3'b001, 'h40); push = 1; clr_ovf = 1; nxt(); push = 0; clr_ovf = 0;
    chk("R6 set beats clear", ovf_trap, 1);
    clr_ovf = 1; nxt(); clr_ovf = 0;
    chk("R6 cleared", ovf_trap, 0);

    // R7 bit 0 forced
    load(3'b001, 'h13);
    chk("R7 sp bit0", sp, 'h12);
    load(3'b010, 'h41); load(3'b001, 'h42);
    push = 1; nxt(); push = 0;
    chk("R7 limit bit0 (0x41 acts as 0x40)", ovf_trap, 0);
    load(3'b100, 'h61); load(3'b001, 'h5E);
    pop = 1; nxt(); pop = 0;
    chk("R7 high limit bit0 (0x61 acts as 0x60)", unf_trap, 0);
    pop = 1; nxt(); pop = 0;
    chk("R7 high limit bit0 trap", unf_trap, 1);
    clear_both();

    // R8 collision
    load(3'b010, 'hFE); load(3'b100, 'h00); load(3'b001, 'h50);
    push = 1; pop = 1; #1;
    chk("R8 addr", ram_addr, 'h50);
    nxt(); push = 0; pop = 0;
    chk("R8 sp", sp, 'h50);
    chk("R8 no ovf", ovf_trap, 0);
    chk("R8 no unf", unf_trap, 0);

    // R9 pointer write overrides access
    wr_sp = 1; wr_data = 'h30; push = 1; nxt(); wr_sp = 0; push = 0;
    chk("R9 sp write wins", sp, 'h30);
    chk("R9 no trap from cancelled push", ovf_trap, 0);
    load(3'b010, 'h80);
    wr_ovl = 1; wr_data = 'h00; push = 1; nxt(); wr_ovl = 0; push = 0;
    chk("R9 old limit used", ovf_trap, 1);
    chk("R9 push done", sp, 'h2E);
    clear_both();
    push = 1; nxt(); push = 0;
    chk("R9 new limit used", ovf_trap, 0);

    finish_run();
  end
endmodule